// File: doc/BRIEF.md
# Floating-Point Control and Status Register Unit

This block holds the 32-bit control and status register of a floating-point unit. The register has two fields: a 3-bit dynamic rounding mode and a 5-bit set of sticky exception flags. Software reaches the register through a CSR port that decodes three aliased addresses. One address shows only the flags, one shows only the rounding mode, and one shows the whole register. Each access is a read, a write, or a swap. A swap returns the old value of the selected view and installs the new one in the same cycle.

The flags of retiring floating-point operations are ORed into the flag field. They stay set until software writes them. No trap is raised. For every operation, the unit also resolves the effective rounding mode from the instruction's 3-bit rm field, and it flags reserved encodings. A 2-bit FS status tracks whether floating-point state has been modified. A parameter selects whether hardware ever moves FS to Dirty.

Top module: `fp_ctrl_status_unit`

## Requirements
- R1: Address 0x003 (full view) reads the rounding mode in bits 7:5 and the flags in bits 4:0. Bits 31:8 always read zero. A write to the full view loads bits 7:5 and 4:0 of the write data and ignores bits 31:8.
- R2: Address 0x002 (rounding view) reads the rounding mode in bits 2:0 with zero elsewhere. A write to it takes only write-data bits 2:0 and leaves the flags unchanged.
- R3: Address 0x001 (flag view) reads the flags in bits 4:0 with zero elsewhere. A write to it takes only write-data bits 4:0 and leaves the rounding mode unchanged.
- R4: The operation codes are 0 read, 1 write, 2 swap and 3 no action.
  - A read or swap returns the pre-access value of the view in the same cycle.
  - A write or no-action returns zero.
  - Write and swap change state from the next cycle on. Read and no-action change nothing.
  - Any other address gives csr_hit=0, returns zero and changes no state.
- R5: The flag bits, from bit 4 down to bit 0, are invalid, divide-by-zero, overflow, underflow and inexact. A valid accrual ORs acc_flags into the field. Flags are cleared only by a CSR write. When a CSR write and an accrual fall in the same cycle, the result is the written value ORed with the accrued flags.
- R6: The rounding codes are 0 RNE, 1 RTZ, 2 RDN, 3 RUP and 4 RMM. eff_rm equals instr_rm when instr_rm is not 7. When instr_rm is 7, eff_rm equals the stored rounding mode.
- R7: rm_illegal is 1 when instr_rm is 5 or 6. It is also 1 when instr_rm is 7 and the stored mode is 5, 6 or 7. Otherwise it is 0.
- R8: Reset sets the rounding mode to 0 (RNE), clears all flags and sets FS to the FS_RESET parameter (default 0).
- R9: With DIRTY_MODE=0, FS changes only through fs_sw_we, which loads fs_sw_val.
- R10: With DIRTY_MODE=1, FS becomes 3 (Dirty) in the cycle after any of these events:
  - a decoded CSR write or swap;
  - fp_reg_write;
  - an accrual with a nonzero flag.

  This takes priority over fs_sw_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | CSR access request |
| csr_addr | input | 12 | CSR address |
| csr_op | input | 2 | 0 read, 1 write, 2 swap, 3 no action |
| csr_wdata | input | 32 | CSR write data |
| csr_hit | output | 1 | Request addresses one of the three views |
| csr_rdata | output | 32 | Old value of the selected view |
| acc_valid | input | 1 | Retiring operation reports flags |
| acc_flags | input | 5 | Exception flags to accrue |
| instr_rm | input | 3 | Instruction rm field |
| eff_rm | output | 3 | Resolved rounding mode |
| rm_illegal | output | 1 | Reserved static or dynamic mode |
| fp_reg_write | input | 1 | Floating-point register file written |
| fs_sw_we | input | 1 | Software write of FS |
| fs_sw_val | input | 2 | FS value written by software |
| fs_status | output | 2 | FS status |

## Verification
The assertions watch every cycle for the following:
- the reserved upper read bits;
- silence on undecoded addresses;
- stickiness of flags without a CSR write;
- that each accrued flag lands;
- that a legal resolved mode never exceeds 4;
- that dynamic selection follows the stored mode;
- the FS rule of each dirty mode.

Only the bench scenarios can show the following:
- the bit placement of the three aliased views;
- swap returning the old value;
- the combined result of a simultaneous write and accrual;
- the full 8-by-8 table of rounding resolution.

Both dirty modes are instantiated side by side on shared stimulus.

// File: rtl/fcsr_pkg.sv
package fcsr_pkg;

  localparam int RM_W    = 3;
  localparam int FLAG_W  = 5;
  localparam int FIELD_W = RM_W + FLAG_W;
  localparam int ADDR_W  = 12;

  localparam logic [ADDR_W-1:0] ADDR_FLAGS = 12'h001;
  localparam logic [ADDR_W-1:0] ADDR_RM    = 12'h002;
  localparam logic [ADDR_W-1:0] ADDR_FULL  = 12'h003;

  localparam logic [1:0]      FS_DIRTY = 2'd3;
  localparam logic [RM_W-1:0] RM_DYN   = 3'd7;
  localparam logic [RM_W-1:0] RM_MAXOK = 3'd4;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_SWAP  = 2'd2,
    OP_NOP   = 2'd3
  } csr_op_e;

  typedef enum logic [1:0] {
    VIEW_NONE,
    VIEW_FLAGS,
    VIEW_RM,
    VIEW_FULL
  } view_e;

  function automatic view_e decode_view(input logic [ADDR_W-1:0] a);
    case (a)
      ADDR_FLAGS: return VIEW_FLAGS;
      ADDR_RM:    return VIEW_RM;
      ADDR_FULL:  return VIEW_FULL;
      default:    return VIEW_NONE;
    endcase
  endfunction

  function automatic logic [FIELD_W-1:0] view_bits(input view_e v,
                                                   input logic [RM_W-1:0] rm,
                                                   input logic [FLAG_W-1:0] fl);
    case (v)
      VIEW_FLAGS: return {{RM_W{1'b0}}, fl};
      VIEW_RM:    return {{FLAG_W{1'b0}}, rm};
      VIEW_FULL:  return {rm, fl};
      default:    return '0;
    endcase
  endfunction

  function automatic logic static_rm_reserved(input logic [RM_W-1:0] r);
    return (r == 3'd5) || (r == 3'd6);
  endfunction

  function automatic logic dyn_rm_reserved(input logic [RM_W-1:0] f);
    return f > RM_MAXOK;
  endfunction

endpackage

// File: rtl/fcsr_view_port.sv
module fcsr_view_port
  import fcsr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic                req,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [1:0]          op,
  input  logic [XLEN-1:0]     wdata,
  input  logic [RM_W-1:0]     cur_rm,
  input  logic [FLAG_W-1:0]   cur_flags,
  output logic                hit,
  output logic                writes,
  output logic [XLEN-1:0]     rdata,
  output logic                wr_rm_en,
  output logic [RM_W-1:0]     wr_rm_val,
  output logic                wr_flags_en,
  output logic [FLAG_W-1:0]   wr_flags_val
);

  view_e view;
  logic  reads;

  assign view   = decode_view(addr);
  assign hit    = req && (view != VIEW_NONE);
  assign reads  = hit && ((op == OP_READ) || (op == OP_SWAP));
  assign writes = hit && ((op == OP_WRITE) || (op == OP_SWAP));

  always_comb begin
    rdata = '0;
    if (reads) rdata[FIELD_W-1:0] = view_bits(view, cur_rm, cur_flags);
  end

  assign wr_rm_en     = writes && ((view == VIEW_RM) || (view == VIEW_FULL));
  assign wr_rm_val    = (view == VIEW_FULL) ? wdata[FIELD_W-1:FLAG_W] : wdata[RM_W-1:0];
  assign wr_flags_en  = writes && ((view == VIEW_FLAGS) || (view == VIEW_FULL));
  assign wr_flags_val = wdata[FLAG_W-1:0];

endmodule

// File: rtl/fcsr_rm_resolve.sv
module fcsr_rm_resolve
  import fcsr_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [RM_W-1:0] instr_rm,
  input  logic [RM_W-1:0] dyn_rm,
  output logic [RM_W-1:0] eff_rm,
  output logic            illegal
);

  logic use_dyn;

  assign use_dyn = (instr_rm == RM_DYN);
  assign eff_rm  = use_dyn ? dyn_rm : instr_rm;
  assign illegal = use_dyn ? dyn_rm_reserved(dyn_rm) : static_rm_reserved(instr_rm);

  AST_LEGAL_MODE_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    !illegal |-> (eff_rm <= RM_MAXOK)); // R7

endmodule

// File: rtl/fcsr_fs_track.sv
module fcsr_fs_track
  import fcsr_pkg::*;
#(
  parameter int         DIRTY_MODE = 1,
  parameter logic [1:0] FS_RESET   = 2'd0
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sw_we,
  input  logic [1:0] sw_val,
  input  logic       state_mod,
  output logic [1:0] fs
);

  generate
    if (DIRTY_MODE != 0) begin : g_precise
      always_ff @(posedge clk) begin
        if (!rst_n)         fs <= FS_RESET;
        else if (state_mod) fs <= FS_DIRTY;
        else if (sw_we)     fs <= sw_val;
      end

      AST_DIRTY_AFTER_MOD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(state_mod) |-> (fs == FS_DIRTY)); // R10
    end else begin : g_never
      logic unused_mod;
      assign unused_mod = state_mod;

      always_ff @(posedge clk) begin
        if (!rst_n)     fs <= FS_RESET;
        else if (sw_we) fs <= sw_val;
      end

      AST_FS_SOFTWARE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(sw_we) |-> $stable(fs)); // R9
    end
  endgenerate

endmodule

// File: rtl/fp_ctrl_status_unit.sv
module fp_ctrl_status_unit
  import fcsr_pkg::*;
#(
  parameter int         XLEN       = 32,
  parameter int         DIRTY_MODE = 1,
  parameter logic [1:0] FS_RESET   = 2'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_req,
  input  logic [11:0]       csr_addr,
  input  logic [1:0]        csr_op,
  input  logic [XLEN-1:0]   csr_wdata,
  output logic              csr_hit,
  output logic [XLEN-1:0]   csr_rdata,
  input  logic              acc_valid,
  input  logic [4:0]        acc_flags,
  input  logic [2:0]        instr_rm,
  output logic [2:0]        eff_rm,
  output logic              rm_illegal,
  input  logic              fp_reg_write,
  input  logic              fs_sw_we,
  input  logic [1:0]        fs_sw_val,
  output logic [1:0]        fs_status
);

  localparam int RSV_LO = FIELD_W;

  logic [RM_W-1:0]   frm_q;
  logic [FLAG_W-1:0] flags_q;

  logic              csr_writes;
  logic              sw_rm_wr;
  logic [RM_W-1:0]   sw_rm_val;
  logic              sw_flag_wr;
  logic [FLAG_W-1:0] sw_flag_val;
  logic [FLAG_W-1:0] hw_flags;
  logic              hw_flag_set;
  logic              fp_state_mod;

  fcsr_view_port #(.XLEN(XLEN)) u_view (
    .req          (csr_req),
    .addr         (csr_addr),
    .op           (csr_op),
    .wdata        (csr_wdata),
    .cur_rm       (frm_q),
    .cur_flags    (flags_q),
    .hit          (csr_hit),
    .writes       (csr_writes),
    .rdata        (csr_rdata),
    .wr_rm_en     (sw_rm_wr),
    .wr_rm_val    (sw_rm_val),
    .wr_flags_en  (sw_flag_wr),
    .wr_flags_val (sw_flag_val)
  );

  assign hw_flags    = acc_valid ? acc_flags : '0;
  assign hw_flag_set = |hw_flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frm_q   <= '0;
      flags_q <= '0;
    end else begin
      if (sw_rm_wr) frm_q <= sw_rm_val;
      flags_q <= (sw_flag_wr ? sw_flag_val : flags_q) | hw_flags;
    end
  end

  AST_RESERVED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[XLEN-1:RSV_LO] == '0); // R1
  AST_MISS_IS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_req && !csr_hit) |-> (csr_rdata == '0)); // R4
  AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_flag_wr) |-> (($past(flags_q) & ~flags_q) == '0)); // R5
  AST_ACCRUED_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(acc_valid) |-> ((flags_q & $past(acc_flags)) == $past(acc_flags))); // R5

  fcsr_rm_resolve u_rm (
    .clk      (clk),
    .rst_n    (rst_n),
    .instr_rm (instr_rm),
    .dyn_rm   (frm_q),
    .eff_rm   (eff_rm),
    .illegal  (rm_illegal)
  );

  AST_DYN_FOLLOWS_FRM: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_rm == RM_DYN) |-> (eff_rm == frm_q)); // R6

  assign fp_state_mod = csr_writes || hw_flag_set || fp_reg_write;

  fcsr_fs_track #(.DIRTY_MODE(DIRTY_MODE), .FS_RESET(FS_RESET)) u_fs (
    .clk       (clk),
    .rst_n     (rst_n),
    .sw_we     (fs_sw_we),
    .sw_val    (fs_sw_val),
    .state_mod (fp_state_mod),
    .fs        (fs_status)
  );

endmodule

// File: tb/test_fp_ctrl_status_unit.sv
module test_fp_ctrl_status_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        csr_req = 1'b0;
  logic [11:0] csr_addr = '0;
  logic [1:0]  csr_op = '0;
  logic [31:0] csr_wdata = '0;
  logic        acc_valid = 1'b0;
  logic [4:0]  acc_flags = '0;
  logic [2:0]  instr_rm = '0;
  logic        fp_reg_write = 1'b0;
  logic        fs_sw_we = 1'b0;
  logic [1:0]  fs_sw_val = '0;

  logic        csr_hit, rm_illegal, n_hit, n_ill;
  logic [31:0] csr_rdata, n_rdata;
  logic [2:0]  eff_rm, n_eff;
  logic [1:0]  fs_status, n_fs;

  int total = 0;
  int bad = 0;
  logic [2:0]  m_rm = '0;
  logic [4:0]  m_flags = '0;
  logic [31:0] rd;
  logic        hit;

  always #10 clk = ~clk;

  fp_ctrl_status_unit #(.DIRTY_MODE(1)) i_fp_ctrl_status_unit (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_hit(csr_hit), .csr_rdata(csr_rdata), .acc_valid(acc_valid),
    .acc_flags(acc_flags), .instr_rm(instr_rm), .eff_rm(eff_rm), .rm_illegal(rm_illegal),
    .fp_reg_write(fp_reg_write), .fs_sw_we(fs_sw_we), .fs_sw_val(fs_sw_val), .fs_status(fs_status));

  fp_ctrl_status_unit #(.DIRTY_MODE(0)) i_fp_ctrl_status_unit_never (
    .clk(clk), .rst_n(rst_n), .csr_req(csr_req), .csr_addr(csr_addr), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_hit(n_hit), .csr_rdata(n_rdata), .acc_valid(acc_valid),
    .acc_flags(acc_flags), .instr_rm(instr_rm), .eff_rm(n_eff), .rm_illegal(n_ill),
    .fp_reg_write(fp_reg_write), .fs_sw_we(fs_sw_we), .fs_sw_val(fs_sw_val), .fs_status(n_fs));

  function automatic logic [31:0] model_full();
    return {24'h0, m_rm, m_flags};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one CSR access: inputs set at a falling edge, result sampled mid-cycle
  task automatic csr(input logic [1:0] op, input logic [11:0] a, input logic [31:0] wd);
    @(negedge clk);
    csr_req = 1'b1; csr_op = op; csr_addr = a; csr_wdata = wd;
    #2;
    rd = csr_rdata; hit = csr_hit;
    @(negedge clk);
    csr_req = 1'b0; csr_op = 2'd0; csr_wdata = '0;
  endtask

  task automatic sw_fs(input logic [1:0] v);
    @(negedge clk); fs_sw_we = 1'b1; fs_sw_val = v;
    @(negedge clk); fs_sw_we = 1'b0;
  endtask

  task automatic accrue(input logic [4:0] f);
    @(negedge clk); acc_valid = 1'b1; acc_flags = f;
    @(negedge clk); acc_valid = 1'b0; acc_flags = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R8 reset state
    chk("R8 fs precise", {30'h0, fs_status}, 32'd0);
    chk("R8 fs never", {30'h0, n_fs}, 32'd0);
    instr_rm = 3'd7; #2;
    chk("R8 dyn mode after reset", {29'h0, eff_rm}, 32'd0);
    instr_rm = 3'd0;
    csr(2'd0, 12'h003, 32'hFFFF_FFFF);
    chk("R8 full after reset", rd, 32'd0);

    // R9/R10 FS tracking
    sw_fs(2'd1);
    chk("R10 sw write precise", {30'h0, fs_status}, 32'd1);
    chk("R9 sw write never", {30'h0, n_fs}, 32'd1);
    csr(2'd0, 12'h003, 32'h0);
    accrue(5'd0);
    chk("R10 read/empty accrual keep fs", {30'h0, fs_status}, 32'd1);
    @(negedge clk); fp_reg_write = 1'b1; @(negedge clk); fp_reg_write = 1'b0;
    chk("R10 regfile write dirty", {30'h0, fs_status}, 32'd3);
    chk("R9 regfile write ignored", {30'h0, n_fs}, 32'd1);
    sw_fs(2'd0);
    csr(2'd1, 12'h001, 32'h0);
    chk("R10 csr write dirty", {30'h0, fs_status}, 32'd3);
    chk("R9 csr write ignored", {30'h0, n_fs}, 32'd0);
    sw_fs(2'd0);
    accrue(5'b00100); m_flags = 5'b00100;
    chk("R10 accrual dirty", {30'h0, fs_status}, 32'd3);
    chk("R9 accrual ignored", {30'h0, n_fs}, 32'd0);
    sw_fs(2'd2);
    csr(2'd2, 12'h004, 32'hFF);
    chk("R10 undecoded keeps fs", {30'h0, fs_status}, 32'd2);
    @(negedge clk); fs_sw_we = 1'b1; fs_sw_val = 2'd1; fp_reg_write = 1'b1;
    @(negedge clk); fs_sw_we = 1'b0; fp_reg_write = 1'b0;
    chk("R10 dirty beats sw write", {30'h0, fs_status}, 32'd3);
    chk("R9 sw write with regfile", {30'h0, n_fs}, 32'd1);

    // R1 full-view sweep with swap
    for (int v = 0; v < 256; v++) begin
      logic [7:0] b;
      b = v[7:0];
      csr(2'd2, 12'h003, {b ^ 8'h5A, ~b, b ^ 8'hC3, b});
      chk("R4 swap full old", rd, model_full());
      m_rm = b[7:5]; m_flags = b[4:0];
      csr(2'd0, 12'h003, 32'hFFFF_FFFF);
      chk("R1 full readback", rd, model_full());
      csr(2'd0, 12'h002, 32'h0);
      chk("R2 rm view read", rd, {29'h0, m_rm});
      csr(2'd0, 12'h001, 32'h0);
      chk("R3 flag view read", rd, {27'h0, m_flags});
    end

    // R2 rounding view writes
    for (int v = 0; v < 32; v++) begin
      csr(2'd2, 12'h002, 32'hDEAD_BE00 | v);
      chk("R2 swap rm old", rd, {29'h0, m_rm});
      m_rm = v[2:0];
      csr(2'd0, 12'h003, 32'h0);
      chk("R2 rm write full", rd, model_full());
    end

    // R3 flag view writes
    for (int v = 0; v < 64; v++) begin
      csr(2'd2, 12'h001, 32'hFFFF_FF00 | v);
      chk("R3 swap flags old", rd, {27'h0, m_flags});
      m_flags = v[4:0];
      csr(2'd0, 12'h003, 32'h0);
      chk("R3 flag write full", rd, model_full());
    end

    // R4 op codes and undecoded addresses
    csr(2'd1, 12'h003, 32'h0000_00A9);
    chk("R4 write returns zero", rd, 32'd0);
    m_rm = 3'b101; m_flags = 5'b01001;
    csr(2'd0, 12'h003, 32'h0000_0012);
    chk("R4 write installed", rd, model_full());
    csr(2'd3, 12'h003, 32'h0000_00FF);
    chk("R4 nop returns zero", rd, 32'd0);
    chk("R4 nop hit", {31'h0, hit}, 32'd1);
    csr(2'd0, 12'h003, 32'h0);
    chk("R4 nop no change", rd, model_full());
    for (int k = 0; k < 4; k++) begin
      logic [11:0] a;
      a = (k == 0) ? 12'h000 : (k == 1) ? 12'h004 : (k == 2) ? 12'h7FF : 12'hC03;
      csr(2'd2, a, 32'h0000_0000);
      chk("R4 miss rdata", rd, 32'd0);
      chk("R4 miss hit", {31'h0, hit}, 32'd0);
    end
    csr(2'd0, 12'h003, 32'h0);
    chk("R4 miss no change", rd, model_full());

    // R5 per-bit accrual and stickiness
    for (int b = 0; b < 5; b++) begin
      csr(2'd1, 12'h001, 32'h0);
      accrue(5'(1 << b));
      repeat (3) @(negedge clk);
      csr(2'd0, 12'h001, 32'h0);
      chk("R5 single flag sticky", rd, 32'(1 << b));
    end
    csr(2'd1, 12'h001, 32'h0); m_flags = '0;
    begin
      logic [7:0] lf;
      lf = 8'hB5;
      for (int i = 0; i < 40; i++) begin
        lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
        if (lf[0] && (i % 8) == 0) begin
          csr(2'd1, 12'h001, 32'h0); m_flags = '0;
        end
        @(negedge clk); acc_valid = lf[0]; acc_flags = lf[5:1];
        if (lf[0]) m_flags = m_flags | lf[5:1];
        @(negedge clk); acc_valid = 1'b0; acc_flags = '0;
        csr(2'd0, 12'h001, 32'h0);
        chk("R5 accrual pattern", rd, {27'h0, m_flags});
      end
    end
    // simultaneous write and accrual
    @(negedge clk);
    csr_req = 1'b1; csr_op = 2'd1; csr_addr = 12'h001; csr_wdata = 32'h0000_0001;
    acc_valid = 1'b1; acc_flags = 5'b10000;
    @(negedge clk);
    csr_req = 1'b0; csr_op = 2'd0; acc_valid = 1'b0; acc_flags = '0;
    csr(2'd0, 12'h001, 32'h0);
    chk("R5 write ORed with accrual", rd, 32'h0000_0011);

    // R6/R7 rounding resolution table
    for (int f = 0; f < 8; f++) begin
      csr(2'd1, 12'h002, 32'(f));
      for (int r = 0; r < 8; r++) begin
        logic [2:0] ee;
        logic       ei;
        @(negedge clk); instr_rm = 3'(r); #2;
        ee = (r == 7) ? 3'(f) : 3'(r);
        ei = (r == 5) || (r == 6) || ((r == 7) && (f >= 5));
        chk("R6 effective mode", {29'h0, eff_rm}, {29'h0, ee});
        chk("R7 reserved mode", {31'h0, rm_illegal}, {31'h0, ei});
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule